// File: doc/BRIEF.md
# Lane-Masked Simple Dual-Port RAM

This block is a single-clock memory with one read port and one write port. Each stored word is divided into equal columns (lanes), and every lane has its own write-enable bit. A write at one address changes only the lanes whose enable bit is set. The other lanes keep what they held.

A read is registered. When the read enable is high, the word at the read address appears on the read data output one clock later. When the read enable is low, the output keeps its value.

A read and a write can target the same address in one cycle. A build-time parameter then picks what the read returns. In write-first mode the read returns the written lanes merged with the old contents of the unwritten lanes. In read-first mode it returns the contents held before the write.

Top module: `lane_mask_sdp_ram`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rd_data` is cleared to zero on that edge. The array contents are not reset.
- R2: When `rd_en` is high at a clock edge, and no collision applies, `rd_data` shows the stored word at `rd_addr` after that edge.
- R3: When `rd_en` is low at a clock edge, `rd_data` keeps its previous value, even if a write to any address happens in that cycle.
- R4: Lane c of a word is bits `[c*COL_W +: COL_W]`. A write stores lane c of `wr_data` at `wr_addr` only when bit c of `wr_en` is set. All other lanes at that address are unchanged.
- R5: With `WRITE_FIRST=1` (the default), a collision with every `wr_en` bit set returns the full new `wr_data` on `rd_data` after that edge.
- R6: With `WRITE_FIRST=1`, a collision with a partial `wr_en` returns a merged word. Enabled lanes come from `wr_data`, and the other lanes show the stored contents.
- R7: With `WRITE_FIRST=0`, a collision returns the contents stored before the write. A later read of that address returns the newly written lanes.
- R8: A collision exists only when all three of these hold: `rd_en` is high, at least one `wr_en` bit is set, and `rd_addr` equals `wr_addr`. If `wr_en` is all zero at the same address, the read returns the stored word.
- R9: `DEPTH` defaults to 1024 words, and the address width is the ceiling of log2 of `DEPTH`. The defaults are `N_COL=4` lanes of `COL_W=8` bits, which gives a 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read data register |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | N_COL*COL_W | Registered read word |
| wr_en | input | N_COL | Per-lane write enables |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | N_COL*COL_W | Write word |

## Verification
The assertions assume that both addresses are below `DEPTH`. They also assume that every read targets an address written earlier, so that the output never carries undefined storage contents. The stimulus first writes the whole address window it uses, and it draws every later address from inside that window. Collisions are forced on purpose in the stimulus, including an all-zero write mask at the read address, so that the collision properties are exercised on both sides of their enabling condition.

// File: rtl/lmsr_pkg.sv
// Shared helpers for the lane-masked RAM.
// Assumes depths of at least 2 words.
package lmsr_pkg;
    // Address width for a given depth, never less than one bit.
    function automatic int addr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/lmsr_hit_detect.sv
// Collision detector: flags, per lane, a same-cycle read and write of one address.
// Assumes the addresses are sampled together with the enables.
module lmsr_hit_detect #(
    parameter int N_COL  = 4,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [N_COL-1:0]  wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [N_COL-1:0]  hit
);
    logic same_addr;

    // Compare the two addresses once for all lanes.
    always_comb same_addr = (rd_addr == wr_addr);

    genvar c;
    generate
        for (c = 0; c < N_COL; c++) begin : g_hit
            // A lane collides only if it is written while read at one address.
            always_comb hit[c] = rd_en & wr_en[c] & same_addr;
        end
    endgenerate

    // R8
    hit_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> rd_en);

    // R8
    hit_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & ~wr_en) == '0));
endmodule

// File: rtl/lmsr_lane.sv
// One lane of storage: a DEPTH x COL_W array with its own write enable
// and a registered read output that resolves collisions per WRITE_FIRST.
// Assumes addresses below DEPTH; storage has no reset.
module lmsr_lane #(
    parameter int DEPTH       = 1024,
    parameter int ADDR_W      = 10,
    parameter int COL_W       = 8,
    parameter bit WRITE_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [COL_W-1:0]  wr_data,
    input  logic              hit,
    output logic [COL_W-1:0]  q
);
    logic [COL_W-1:0] mem [DEPTH];

    // Store the lane when its enable is set.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Register the read; nonblocking storage update gives old data for read-first.
    always_ff @(posedge clk) begin
        if (!rst_n)                  q <= '0;
        else if (rd_en) begin
            if (WRITE_FIRST && hit)  q <= wr_data;
            else                     q <= mem[rd_addr];
        end
    end

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(q));

    generate
        if (WRITE_FIRST) begin : g_wf_chk
            // R5
            wf_new_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && wr_en && rd_addr == wr_addr) |=> (q == $past(wr_data)));
        end
    endgenerate
endmodule

// File: rtl/lane_mask_sdp_ram.sv
// Top: lane-masked simple dual-port RAM, one clock, registered read.
// Splits the word into N_COL lanes; each lane is an independent array.
// Assumes addresses below DEPTH and reads only of written locations.
module lane_mask_sdp_ram #(
    parameter int DEPTH       = 1024,
    parameter int COL_W       = 8,
    parameter int N_COL       = 4,
    parameter bit WRITE_FIRST = 1'b1,
    localparam int ADDR_W     = lmsr_pkg::addr_bits(DEPTH),
    localparam int DATA_W     = N_COL * COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_COL-1:0]  wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [N_COL-1:0] hit;

    lmsr_hit_detect #(.N_COL(N_COL), .ADDR_W(ADDR_W)) u_hit (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .hit(hit)
    );

    genvar c;
    generate
        for (c = 0; c < N_COL; c++) begin : g_lane
            lmsr_lane #(
                .DEPTH(DEPTH), .ADDR_W(ADDR_W), .COL_W(COL_W),
                .WRITE_FIRST(WRITE_FIRST)
            ) u_lane (
                .clk(clk), .rst_n(rst_n),
                .rd_en(rd_en), .rd_addr(rd_addr),
                .wr_en(wr_en[c]), .wr_addr(wr_addr),
                .wr_data(wr_data[c*COL_W +: COL_W]),
                .hit(hit[c]),
                .q(rd_data[c*COL_W +: COL_W])
            );
        end
    endgenerate

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));
endmodule

// File: tb/lane_mask_sdp_ram_test.sv
module lane_mask_sdp_ram_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 1024;
    localparam int COL_W  = 8;
    localparam int N_COL  = 4;
    localparam int ADDR_W = 10;   // R9: clog2(1024)
    localparam int DATA_W = 32;   // R9: 4 lanes x 8 bits
    localparam int WIN    = 32;

    logic clk = 0, rst_n = 0, rd_en = 0;
    logic [ADDR_W-1:0] rd_addr = '0, wr_addr = '0;
    logic [N_COL-1:0]  wr_en = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_wf, rd_rf;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [DATA_W-1:0] model [WIN];
    logic [DATA_W-1:0] last_wf = '0, last_rf = '0;
    logic [DATA_W-1:0] q_wf [$];
    logic [DATA_W-1:0] q_rf [$];
    string q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_mask_sdp_ram #(.DEPTH(DEPTH), .COL_W(COL_W), .N_COL(N_COL), .WRITE_FIRST(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_wf),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    lane_mask_sdp_ram #(.DEPTH(DEPTH), .COL_W(COL_W), .N_COL(N_COL), .WRITE_FIRST(1'b0)) uut_rf (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_rf),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    // Driver: one operation per cycle; expected values pushed to the scoreboard.
    task automatic op(input logic rd, input int ra, input logic [N_COL-1:0] we,
                      input int wa, input logic [DATA_W-1:0] wd, input string tag);
        logic [DATA_W-1:0] e_wf, e_rf;
        @(negedge clk);
        rd_en = rd; rd_addr = ADDR_W'(ra); wr_en = we; wr_addr = ADDR_W'(wa); wr_data = wd;
        if (rd) begin
            e_rf = model[ra];
            e_wf = model[ra];
            for (int c = 0; c < N_COL; c++)
                if (we[c] && wa == ra) e_wf[c*COL_W +: COL_W] = wd[c*COL_W +: COL_W];
            last_wf = e_wf; last_rf = e_rf;
        end
        q_wf.push_back(last_wf); q_rf.push_back(last_rf); q_tag.push_back(tag);
        for (int c = 0; c < N_COL; c++)
            if (we[c]) model[wa][c*COL_W +: COL_W] = wd[c*COL_W +: COL_W];
    endtask

    // Monitor: after each edge, compare both instances against the queued values.
    initial begin
        forever begin
            @(posedge clk); #2;
            if (q_wf.size() > 0) begin
                logic [DATA_W-1:0] ew, er;
                string t;
                ew = q_wf.pop_front(); er = q_rf.pop_front(); t = q_tag.pop_front();
                n_chk += 2;
                if (rd_wf !== ew) begin
                    n_bad++;
                    $display("FAIL %s write-first: actual %h expected %h", t, rd_wf, ew);
                end
                if (rd_rf !== er) begin
                    n_bad++;
                    $display("FAIL %s read-first: actual %h expected %h", t, rd_rf, er);
                end
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: output cleared by reset, nothing read yet
        op(0, 0, '0, 0, '0, "R1");
        // R3: fill window while idle, output must hold at zero
        for (int a = 0; a < WIN; a++) op(0, 0, '1, a, $urandom, "R3");
        // R2: back-to-back reads
        for (int a = 0; a < WIN; a++) op(1, a, '0, 0, '0, "R2");
        // R4: masked writes away from the read address, then read back
        for (int a = 0; a < 8; a++) op(1, a + 16, 4'(a * 5 + 1), a, $urandom, "R4");
        for (int a = 0; a < 8; a++) op(1, a, '0, 0, '0, "R4");
        // R5 / R7: full-mask collision
        op(1, 3, '1, 3, 32'hA1B2C3D4, "R5");
        op(1, 3, '0, 0, '0, "R7");
        // R6 / R7: partial-mask collision
        op(1, 5, 4'b0101, 5, 32'h11223344, "R6");
        op(1, 5, 4'b1000, 5, 32'hFFEEDDCC, "R6");
        op(1, 5, '0, 0, '0, "R7");
        // R8: same address with empty mask is no collision
        op(1, 7, '0, 7, 32'hDEADBEEF, "R8");
        // R3 / R8: write at the held address while read is off
        op(0, 7, '1, 7, 32'h0BADF00D, "R3");
        op(1, 7, '0, 0, '0, "R8");
        // R4 mixed random traffic with frequent collisions
        for (int i = 0; i < 400; i++) begin
            int ra, wa;
            ra = $urandom_range(WIN - 1);
            wa = ($urandom_range(1) == 1) ? ra : $urandom_range(WIN - 1);
            op(1'($urandom), ra, 4'($urandom), wa, $urandom, "R4");
        end
        op(0, 0, '0, 0, '0, "R3");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule